// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Controller

This block keeps the hypervisor-owned control word of a virtual interrupt CPU interface. The word holds a global enable, a set of maintenance-condition enables, a few trap-control bits that other logic consumes, and a 5-bit counter. The counter records virtual deactivations that found no List Register to retire. A hypervisor uses it to run more active virtual interrupts than it has List Registers. It then learns, through the maintenance interrupt, that deactivations were missed.

The block watches summaries of List Register occupancy (a 2-bit state per entry plus a valid flag per entry) and the two virtual group enables. From these it computes the maintenance conditions. Each condition is gated by its own enable bit. The results are ORed and qualified by the global enable, and the outcome is registered onto a level-sensitive maintenance interrupt. Strobes for virtual end-of-interrupt writes and deactivate writes arrive with their interrupt ID, EOI mode, a List Register hit flag and a virtual-SGI flag, and they advance the counter. The global enable is also brought out, so that acknowledge logic can return the spurious ID while the interface is off.

Top module: `vintc_maint_ctrl`

## Requirements
- R1: After reset the readback word is 0, the maintenance interrupt is 0 and the interface enable output is 0.
- R2: Readback bits [26:15] and bit 9 are always 0 and ignore writes. Bits [31:27], [14:10] and [8:0] read back the last value written.
- R3: An end-of-interrupt strobe with ID below 8192, EOI mode 0 and no List Register hit increments the counter held in bits [31:27] by one, visible on readback after the next clock edge.
- R4: A deactivate strobe with ID below 8192, EOI mode 1 and no List Register hit increments the counter by one.
- R5: The counter does not change when the ID is 8192 or above, when a List Register hit is flagged, when the EOI mode does not match the strobe type, or when no strobe is present.
- R6: While bit 8 is 1, a strobe flagged as a virtual SGI does not increment the counter. While bit 8 is 0, such a strobe counts normally.
- R7: The counter wraps from 31 to 0 on increment.
- R8: A register write in the same cycle as a qualifying strobe sets the counter to the written value, and the increment is lost.
- R9: With bit 3 set, the maintenance condition holds while no List Register state field (entry i at lr_state[2i+1:2i]) equals 2'b01.
- R10: With bit 2 set, the maintenance condition holds while the counter is nonzero.
- R11: With bit 1 set, the maintenance condition holds while at most one lr_valid bit is 1.
- R12: Each group bit adds one maintenance condition. Bit 7 holds while the group 1 enable is 0, bit 6 while it is 1, bit 5 while the group 0 enable is 0, and bit 4 while the group 0 enable is 1.
- R13: The maintenance interrupt equals the OR of the enabled conditions ANDed with bit 0, registered one cycle. While bit 0 is 0 the maintenance interrupt and the interface enable output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word readback |
| lr_state | input | 2*NUM_LR | Per-entry List Register state, entry i at [2i+1:2i] |
| lr_valid | input | NUM_LR | Per-entry List Register valid flags |
| grp0_en | input | 1 | Virtual group 0 enable |
| grp1_en | input | 1 | Virtual group 1 enable |
| eoi_wr | input | 1 | Virtual end-of-interrupt write strobe |
| dir_wr | input | 1 | Virtual deactivate write strobe |
| evt_id | input | ID_W | Interrupt ID carried by the strobe |
| evt_eoimode | input | 1 | EOI mode in force for the strobe |
| evt_lr_hit | input | 1 | A matching List Register was found |
| evt_vsgi | input | 1 | The interrupt is a virtual SGI |
| maint_irq | output | 1 | Level-sensitive maintenance interrupt |
| vif_enable | output | 1 | Interface enable; 0 forces a spurious acknowledge ID |

## Verification
The hardest situation to reach from the ports is the 31-to-0 counter wrap together with a software write colliding with an increment. Stepping the counter there through strobes is slow and hides the collision. The stimulus instead loads the counter directly through the register port, so the wrap takes a single strobe. It then raises the write strobe and a qualifying deactivation in the same cycle to check that the written value survives. The qualification logic is swept over every combination of strobe type, EOI mode, hit, SGI flag, suppression bit and an ID on each side of the 8192 boundary.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 5;
    localparam int CNT_LSB   = 27;
    localparam int LPI_FIRST = 8192;

    typedef struct packed {
        logic trap_dir;
        logic trap_sei;
        logic trap_g1;
        logic trap_g0;
        logic trap_common;
        logic sgi_no_count;
        logic g1_off_ie;
        logic g1_on_ie;
        logic g0_off_ie;
        logic g0_on_ie;
        logic no_pend_ie;
        logic lr_miss_ie;
        logic under_ie;
        logic enable;
    } ctl_t;

    function automatic ctl_t word_to_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c = {w[14:10], w[8:0]};
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_to_word(input ctl_t c,
                                                      input logic [CNT_W-1:0] cnt);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[31:27]   = cnt;
        w[14:10]   = {c.trap_dir, c.trap_sei, c.trap_g1, c.trap_g0, c.trap_common};
        w[8:0]     = {c.sgi_no_count, c.g1_off_ie, c.g1_on_ie, c.g0_off_ie,
                      c.g0_on_ie, c.no_pend_ie, c.lr_miss_ie, c.under_ie, c.enable};
        return w;
    endfunction

endpackage

// File: rtl/hcr_ctl_reg.sv
module hcr_ctl_reg
    import vmaint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output ctl_t              ctl
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (we)
            ctl_q <= word_to_ctl(wdata);
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/eoi_counter.sv
module eoi_counter
    import vmaint_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wcnt,
    input  logic             eoi_wr,
    input  logic             dir_wr,
    input  logic [ID_W-1:0]  id,
    input  logic             eoimode,
    input  logic             lr_hit,
    input  logic             vsgi,
    input  logic             sgi_block,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      id_ext;
    logic             below_lpi;
    logic             path_ok;
    logic             inc;

    assign id_ext    = 32'(id);
    assign below_lpi = id_ext < 32'(LPI_FIRST);
    assign path_ok   = (eoi_wr && !eoimode) || (dir_wr && eoimode);
    assign inc       = path_ok && below_lpi && !lr_hit && !(vsgi && sgi_block);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (we)
            cnt_q <= wcnt;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R3 / R4 / R7: a qualifying strobe steps the count by one, modulo 32
    p_inc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R5: with no qualifying event and no write the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!inc && !we) |=> $stable(cnt_q));

    // R8: the software write decides the next count
    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> (cnt_q == $past(wcnt)));

endmodule

// File: rtl/maint_eval.sv
module maint_eval
    import vmaint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  ctl_t                ctl,
    input  logic                cnt_nz,
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic [NUM_LR-1:0]   lr_valid,
    input  logic                grp0_en,
    input  logic                grp1_en,
    output logic                irq
);
    localparam int VC_W = $clog2(NUM_LR + 1);

    logic [NUM_LR-1:0] pend_vec;
    logic [VC_W-1:0]   vcount;
    logic              no_pend;
    logic              under;
    logic              any_cond;
    logic              irq_q;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_pend
        assign pend_vec[i] = (lr_state[2*i +: 2] == 2'b01);
    end

    always_comb begin
        vcount = '0;
        for (int i = 0; i < NUM_LR; i++)
            vcount = vcount + VC_W'(lr_valid[i]);
    end

    assign no_pend = ~|pend_vec;
    assign under   = vcount <= VC_W'(1);

    assign any_cond = (ctl.no_pend_ie && no_pend)
                    | (ctl.lr_miss_ie && cnt_nz)
                    | (ctl.under_ie   && under)
                    | (ctl.g1_off_ie  && !grp1_en)
                    | (ctl.g1_on_ie   &&  grp1_en)
                    | (ctl.g0_off_ie  && !grp0_en)
                    | (ctl.g0_on_ie   &&  grp0_en);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= ctl.enable && any_cond;
    end

    assign irq = irq_q;

    // R13: a disabled interface raises no maintenance interrupt next cycle
    p_off_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !ctl.enable |=> !irq_q);

endmodule

// File: rtl/vintc_maint_ctrl.sv
module vintc_maint_ctrl
    import vmaint_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ID_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic [NUM_LR-1:0]   lr_valid,
    input  logic                grp0_en,
    input  logic                grp1_en,
    input  logic                eoi_wr,
    input  logic                dir_wr,
    input  logic [ID_W-1:0]     evt_id,
    input  logic                evt_eoimode,
    input  logic                evt_lr_hit,
    input  logic                evt_vsgi,
    output logic                maint_irq,
    output logic                vif_enable
);
    ctl_t             ctl;
    logic [CNT_W-1:0] cnt;

    hcr_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctl   (ctl)
    );

    eoi_counter #(.ID_W(ID_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .wcnt      (reg_wdata[CNT_LSB +: CNT_W]),
        .eoi_wr    (eoi_wr),
        .dir_wr    (dir_wr),
        .id        (evt_id),
        .eoimode   (evt_eoimode),
        .lr_hit    (evt_lr_hit),
        .vsgi      (evt_vsgi),
        .sgi_block (ctl.sgi_no_count),
        .cnt       (cnt)
    );

    maint_eval #(.NUM_LR(NUM_LR)) u_eval (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cnt_nz   (|cnt),
        .lr_state (lr_state),
        .lr_valid (lr_valid),
        .grp0_en  (grp0_en),
        .grp1_en  (grp1_en),
        .irq      (maint_irq)
    );

    assign reg_rdata  = ctl_to_word(ctl, cnt);
    assign vif_enable = ctl.enable;

    // R2: reserved positions never read as one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[26:15] == '0) && !reg_rdata[9]);

    // R13: the maintenance interrupt only follows a cycle in which the interface was on
    p_irq_needs_en_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(maint_irq) |-> $past(vif_enable));

endmodule

// File: tb/vintc_maint_ctrl_tb.sv
module vintc_maint_ctrl_tb;
    localparam int NUM_LR = 4;
    localparam int ID_W   = 16;

    logic                clk = 1'b0;
    logic                rst;
    logic                reg_we;
    logic [31:0]         reg_wdata;
    logic [31:0]         reg_rdata;
    logic [2*NUM_LR-1:0] lr_state;
    logic [NUM_LR-1:0]   lr_valid;
    logic                grp0_en, grp1_en;
    logic                eoi_wr, dir_wr;
    logic [ID_W-1:0]     evt_id;
    logic                evt_eoimode, evt_lr_hit, evt_vsgi;
    logic                maint_irq, vif_enable;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vintc_maint_ctrl #(.NUM_LR(NUM_LR), .ID_W(ID_W)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lr_state(lr_state), .lr_valid(lr_valid),
        .grp0_en(grp0_en), .grp1_en(grp1_en), .eoi_wr(eoi_wr), .dir_wr(dir_wr),
        .evt_id(evt_id), .evt_eoimode(evt_eoimode), .evt_lr_hit(evt_lr_hit),
        .evt_vsgi(evt_vsgi), .maint_irq(maint_irq), .vif_enable(vif_enable)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic fire(input logic is_dir, input logic [ID_W-1:0] id, input logic mode,
                        input logic hit, input logic sgi);
        eoi_wr = !is_dir;
        dir_wr = is_dir;
        evt_id = id;
        evt_eoimode = mode;
        evt_lr_hit = hit;
        evt_vsgi = sgi;
        tick();
        eoi_wr = 1'b0;
        dir_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 0; reg_wdata = 0; lr_state = 0; lr_valid = 0;
        grp0_en = 0; grp1_en = 0; eoi_wr = 0; dir_wr = 0; evt_id = 0;
        evt_eoimode = 0; evt_lr_hit = 0; evt_vsgi = 0;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 irq", {31'b0, maint_irq}, 32'h0);
        check("R1 vif_enable", {31'b0, vif_enable}, 32'h0);

        // R2 reserved bits ignore writes, the rest read back
        write_reg(32'hFFFF_FFFF);
        check("R2 all ones", reg_rdata, 32'hF800_7DFF);
        write_reg(32'h5000_8200);
        check("R2 reserved only", reg_rdata, 32'h5000_0000);
        write_reg(32'h0000_0000);

        // R3 R4 R5 R6 qualification sweep
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 2; m++)
                for (int h = 0; h < 2; h++)
                    for (int g = 0; g < 2; g++)
                        for (int b = 0; b < 2; b++)
                            for (int k = 0; k < 3; k++) begin
                                logic [ID_W-1:0] id;
                                logic exp_inc;
                                id = (k == 0) ? 16'd0 : (k == 1) ? 16'd8191 : 16'd8192;
                                write_reg({23'b0, b[0], 8'b0});
                                fire(s[0], id, m[0], h[0], g[0]);
                                exp_inc = ((s == 0) ? (m == 0) : (m == 1)) && (k < 2)
                                          && (h == 0) && !(g == 1 && b == 1);
                                if (s == 0)
                                    check("R3/R5/R6 eoi count", {27'b0, reg_rdata[31:27]},
                                          {31'b0, exp_inc});
                                else
                                    check("R4/R5/R6 dir count", {27'b0, reg_rdata[31:27]},
                                          {31'b0, exp_inc});
                            end

        // R5 no strobe
        write_reg(32'h1800_0000);
        evt_id = 0; evt_eoimode = 0; evt_lr_hit = 0; evt_vsgi = 0;
        tick(); tick();
        check("R5 idle hold", {27'b0, reg_rdata[31:27]}, 32'd3);

        // R3 repeated counting
        write_reg(32'h0);
        for (int i = 0; i < 7; i++) fire(1'b0, 16'd40, 1'b0, 1'b0, 1'b0);
        check("R3 seven steps", {27'b0, reg_rdata[31:27]}, 32'd7);

        // R7 wrap
        write_reg(32'hF800_0000);
        fire(1'b1, 16'd5, 1'b1, 1'b0, 1'b0);
        check("R7 wrap", {27'b0, reg_rdata[31:27]}, 32'd0);

        // R8 write beats increment
        eoi_wr = 1'b1; evt_id = 16'd3; evt_eoimode = 0; evt_lr_hit = 0; evt_vsgi = 0;
        write_reg(32'h2800_0000);
        eoi_wr = 1'b0;
        check("R8 write wins", {27'b0, reg_rdata[31:27]}, 32'd5);

        // R10 counter nonzero condition
        write_reg(32'h1800_0005);
        tick();
        check("R10 nonzero", {31'b0, maint_irq}, 32'd1);
        write_reg(32'h0000_0005);
        tick();
        check("R10 zero", {31'b0, maint_irq}, 32'd0);
        write_reg(32'h1800_0004);
        tick();
        check("R13 disabled", {31'b0, maint_irq}, 32'd0);
        check("R13 vif off", {31'b0, vif_enable}, 32'd0);

        // R9 sweep over all state patterns
        write_reg(32'h0000_0009);
        lr_valid = 4'hF;
        for (int p = 0; p < 256; p++) begin
            logic exp;
            lr_state = p[7:0];
            tick(); tick();
            exp = 1'b1;
            for (int e = 0; e < NUM_LR; e++)
                if (((p >> (2 * e)) & 3) == 1) exp = 1'b0;
            check("R9 no pending", {31'b0, maint_irq}, {31'b0, exp});
        end

        // R11 sweep over valid patterns
        write_reg(32'h0000_0003);
        lr_state = 8'h55;
        for (int v = 0; v < 16; v++) begin
            logic exp;
            lr_valid = v[3:0];
            tick(); tick();
            exp = ($countones(v[3:0]) <= 1);
            check("R11 underflow", {31'b0, maint_irq}, {31'b0, exp});
        end
        lr_valid = 4'hF;

        // R12 R13 group condition sweep, with and without global enable
        for (int en = 0; en < 2; en++)
            for (int e = 0; e < 16; e++) begin
                write_reg({24'b0, e[3:0], 3'b000, en[0]});
                for (int gg = 0; gg < 4; gg++) begin
                    logic exp;
                    grp0_en = gg[0];
                    grp1_en = gg[1];
                    tick(); tick();
                    exp = (e[3] && !gg[1]) || (e[2] && gg[1]) ||
                          (e[1] && !gg[0]) || (e[0] && gg[0]);
                    exp = exp && (en == 1);
                    if (en == 1)
                        check("R12 group", {31'b0, maint_irq}, {31'b0, exp});
                    else
                        check("R13 gated", {31'b0, maint_irq}, {31'b0, exp});
                end
                check("R13 vif_enable", {31'b0, vif_enable}, {31'b0, en[0]});
            end

        // R13 one-cycle registered latency
        grp0_en = 1'b0;
        write_reg(32'h0000_0021);
        tick();
        check("R13 settled", {31'b0, maint_irq}, 32'd1);
        grp0_en = 1'b1;
        #1;
        check("R13 held before edge", {31'b0, maint_irq}, 32'd1);
        tick();
        check("R13 after edge", {31'b0, maint_irq}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule